// File: doc/BRIEF.md
# Neighbour-Conditioned Page Retry Corrector

This block takes over when a flash page read with the global read references has failed its ECC decode. It holds three page images side by side: the failed page, and the LSB and MSB pages of the adjacent wordline. Together, the two neighbour pages give every cell of the failed page a 2-bit neighbour value. The block then works through the four possible neighbour values one at a time. For each one, it asks the flash interface to re-read the failed page using the reference tuned for that neighbour value. Only the cells whose neighbour holds that value take the freshly read bit; every other cell keeps its current bit. The updated page is then offered to the ECC decoder.

Candidates run in a fixed priority order. The first ECC success ends the procedure. If the last candidate also fails, the page is reported as uncorrectable. Updates accumulate across rounds, and the buffer stays intact after the block returns to idle, so the caller can read it through `page_q`. Data moves one word per beat, and each accepted re-read word is merged in the cycle it arrives.

Top module: `nbr_retry_corrector`

## Requirements
- R1: After reset the block is idle, with `busy`, `rd_req`, `ecc_submit` and `done` all low. A `start` pulse is acted on only while idle; a `start` seen while busy, including in the cycle an ECC verdict arrives, has no effect.
- R2: After `start`, each cycle with `ld_valid` high captures one word of the failed page and one word of each neighbour page, in ascending word order, until all words are held. Cycles with `ld_valid` low do not advance the word index.
- R3: The neighbour value of cell i is `{msb_bit, lsb_bit}`. Candidates are presented on `ref_sel` in the order 2'b11, 2'b10, 2'b01, 2'b00.
- R4: `rd_req` stays high, and `ref_sel` stays constant, from the first cycle of a re-read until its last response word is accepted. Each candidate gets exactly one re-read.
- R5: On each cycle with `rd_valid` during a re-read, bit i of the current word is replaced by the re-read bit exactly when that cell's neighbour value equals the current candidate. All other bits are unchanged. Bit i of word w appears at `page_q[w*WORD_BITS+i]`.
- R6: Merges accumulate. Cells updated in an earlier round keep their updated value in later rounds.
- R7: In the cycle after the last response word is accepted, `ecc_submit` rises and stays high until `ecc_pass` or `ecc_fail` is seen. It is never high together with `rd_req`. `rd_valid` outside a re-read has no effect on the page.
- R8: When `ecc_pass` is seen, `done` pulses in the next cycle with `uncorrectable` low. The block is then idle and issues no further re-read.
- R9: When `ecc_fail` is seen for candidate 2'b00, `done` pulses in the next cycle with `uncorrectable` high. The block returns to idle, and `page_q` holds its contents while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Trigger after a failed normal decode |
| ld_valid | input | 1 | Load beat valid |
| ld_page | input | WORD_BITS | Failed page word |
| ld_nbr_lsb | input | WORD_BITS | Neighbour LSB page word |
| ld_nbr_msb | input | WORD_BITS | Neighbour MSB page word |
| rd_req | output | 1 | Re-read request, held for the whole re-read |
| ref_sel | output | 2 | Neighbour value whose tuned reference to use |
| rd_valid | input | 1 | Re-read response word valid |
| rd_data | input | WORD_BITS | Re-read response word |
| ecc_submit | output | 1 | Page offered to the ECC decoder |
| ecc_pass | input | 1 | ECC decode succeeded |
| ecc_fail | input | 1 | ECC decode failed |
| page_q | output | PAGE_BITS | Working page buffer |
| busy | output | 1 | Procedure in progress |
| done | output | 1 | One-cycle completion pulse |
| uncorrectable | output | 1 | Qualifies `done`: every candidate failed |

## Verification
Two events can land in the same cycle. An ECC verdict can coincide with a new `start`, and stray `rd_valid` data can arrive while the page sits with the decoder. The bench provokes both: during the submit phase it drives junk response words together with `start`, and it raises `start` again in the exact cycle of the verdict. It then judges the outcome at the ports. The final page must match the model built only from legitimate re-reads, and `busy` must stay low after `done`, showing that neither the trigger nor the junk was taken.

// File: rtl/nac_pkg.sv
// Shared types for the neighbour-conditioned retry corrector.
// Assumes a 2-bit neighbour value formed as {msb_bit, lsb_bit}.
package nac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_READ  = 2'd2,
        ST_CHECK = 2'd3
    } nac_state_e;

    localparam int NUM_CAND = 4;

    // Round index 0..3 maps to neighbour value 11, 10, 01, 00.
    function automatic logic [1:0] cand_of(input logic [1:0] round_idx);
        return ~round_idx;
    endfunction
endpackage

// File: rtl/nac_merge_lane.sv
// Per-bit comparator and pass gate for one buffer word.
// A bit takes the re-read value only when its neighbour pair equals the
// current candidate. Purely combinational.
module nac_merge_lane #(
    parameter int WORD_BITS = 16
) (
    input  logic [WORD_BITS-1:0] old_word,
    input  logic [WORD_BITS-1:0] nbr_lsb,
    input  logic [WORD_BITS-1:0] nbr_msb,
    input  logic [WORD_BITS-1:0] reread,
    input  logic [1:0]           cand,
    output logic [WORD_BITS-1:0] new_word
);
    for (genvar b = 0; b < WORD_BITS; b++) begin : g_bit
        logic hit;
        // Compare this cell's neighbour pair with the candidate.
        assign hit = (nbr_msb[b] == cand[1]) && (nbr_lsb[b] == cand[0]);
        // Pass gate: choose the re-read bit on a match.
        assign new_word[b] = hit ? reread[b] : old_word[b];
    end
endmodule

// File: rtl/nac_page_store.sv
// Word-organised storage for the working page and both neighbour pages.
// Assumes at most one of ld_en / mg_en is high per cycle. Word idx is
// read combinationally for the merge lane.
module nac_page_store #(
    parameter int WORD_BITS = 16,
    parameter int WORDS     = 4,
    parameter int IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_en,
    input  logic                       mg_en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [WORD_BITS-1:0]       ld_page,
    input  logic [WORD_BITS-1:0]       ld_lsb,
    input  logic [WORD_BITS-1:0]       ld_msb,
    input  logic [WORD_BITS-1:0]       mg_word,
    output logic [WORD_BITS-1:0]       sel_page,
    output logic [WORD_BITS-1:0]       sel_lsb,
    output logic [WORD_BITS-1:0]       sel_msb,
    output logic [WORDS*WORD_BITS-1:0] page_flat
);
    logic [WORD_BITS-1:0] pg_a  [WORDS];
    logic [WORD_BITS-1:0] lsb_a [WORDS];
    logic [WORD_BITS-1:0] msb_a [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_BITS-1:0] pg_r, lsb_r, msb_r;
        logic                 here;
        assign here = (idx == IDX_W'(g));

        // Hold one word of each page; load writes all three, merge only the page.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pg_r  <= '0;
                lsb_r <= '0;
                msb_r <= '0;
            end else if (ld_en && here) begin
                pg_r  <= ld_page;
                lsb_r <= ld_lsb;
                msb_r <= ld_msb;
            end else if (mg_en && here) begin
                pg_r  <= mg_word;
            end
        end

        assign pg_a[g]  = pg_r;
        assign lsb_a[g] = lsb_r;
        assign msb_a[g] = msb_r;
        assign page_flat[g*WORD_BITS +: WORD_BITS] = pg_r;
    end

    assign sel_page = pg_a[idx];
    assign sel_lsb  = lsb_a[idx];
    assign sel_msb  = msb_a[idx];
endmodule

// File: rtl/nac_seq.sv
// Control sequencer: load, then per candidate a re-read with merge and an
// ECC check, until a pass or until all candidates are used.
// Assumes the responder delivers WORDS rd_valid beats per re-read.
module nac_seq
    import nac_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ld_valid,
    input  logic             rd_valid,
    input  logic             ecc_pass,
    input  logic             ecc_fail,
    output logic [IDX_W-1:0] idx,
    output logic             ld_en,
    output logic             mg_en,
    output logic [1:0]       cand,
    output logic             rd_req,
    output logic             ecc_submit,
    output logic             busy,
    output logic             done,
    output logic             uncorrectable
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
    localparam logic [1:0]       LAST_RND = 2'(NUM_CAND - 1);

    nac_state_e       state;
    logic [1:0]       round_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q, unc_q;

    // Decode strobes and status from the current state.
    always_comb begin
        ld_en      = (state == ST_LOAD) && ld_valid;
        mg_en      = (state == ST_READ) && rd_valid;
        rd_req     = (state == ST_READ);
        ecc_submit = (state == ST_CHECK);
        busy       = (state != ST_IDLE);
    end

    // Advance state, word index and candidate round; emit completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            round_q <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            unc_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unc_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_LOAD;
                        round_q <= '0;
                        idx_q   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (ld_valid) begin
                        if (idx_q == LAST_IDX) begin
                            idx_q <= '0;
                            state <= ST_READ;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_valid) begin
                        if (idx_q == LAST_IDX) begin
                            idx_q <= '0;
                            state <= ST_CHECK;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_CHECK: begin
                    if (ecc_pass) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (ecc_fail) begin
                        if (round_q == LAST_RND) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            unc_q  <= 1'b1;
                        end else begin
                            round_q <= round_q + 1'b1;
                            state   <= ST_READ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign idx           = idx_q;
    assign cand          = cand_of(round_q);
    assign done          = done_q;
    assign uncorrectable = unc_q;
endmodule

// File: rtl/nbr_retry_corrector.sv
// Top level of the neighbour-conditioned retry corrector.
// Assumes PAGE_BITS is a whole multiple of WORD_BITS and at least two words.
module nbr_retry_corrector #(
    parameter int PAGE_BITS = 64,
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ld_valid,
    input  logic [WORD_BITS-1:0] ld_page,
    input  logic [WORD_BITS-1:0] ld_nbr_lsb,
    input  logic [WORD_BITS-1:0] ld_nbr_msb,
    output logic                 rd_req,
    output logic [1:0]           ref_sel,
    input  logic                 rd_valid,
    input  logic [WORD_BITS-1:0] rd_data,
    output logic                 ecc_submit,
    input  logic                 ecc_pass,
    input  logic                 ecc_fail,
    output logic [PAGE_BITS-1:0] page_q,
    output logic                 busy,
    output logic                 done,
    output logic                 uncorrectable
);
    localparam int WORDS = PAGE_BITS / WORD_BITS;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [IDX_W-1:0]     idx;
    logic                 ld_en, mg_en;
    logic [1:0]           cand;
    logic [WORD_BITS-1:0] sel_page, sel_lsb, sel_msb, mg_word;

    nac_seq #(.WORDS(WORDS), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
        .rd_valid(rd_valid), .ecc_pass(ecc_pass), .ecc_fail(ecc_fail),
        .idx(idx), .ld_en(ld_en), .mg_en(mg_en), .cand(cand),
        .rd_req(rd_req), .ecc_submit(ecc_submit), .busy(busy),
        .done(done), .uncorrectable(uncorrectable)
    );

    nac_page_store #(.WORD_BITS(WORD_BITS), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .mg_en(mg_en), .idx(idx),
        .ld_page(ld_page), .ld_lsb(ld_nbr_lsb), .ld_msb(ld_nbr_msb),
        .mg_word(mg_word), .sel_page(sel_page), .sel_lsb(sel_lsb),
        .sel_msb(sel_msb), .page_flat(page_q)
    );

    nac_merge_lane #(.WORD_BITS(WORD_BITS)) u_lane (
        .old_word(sel_page), .nbr_lsb(sel_lsb), .nbr_msb(sel_msb),
        .reread(rd_data), .cand(cand), .new_word(mg_word)
    );

    assign ref_sel = cand;
endmodule

// File: rtl/nac_checker.sv
// Temporal checks on the corrector's ports; bound into the top module.
// Assumes synchronous active-low reset.
module nac_checker #(
    parameter int PAGE_BITS = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_req,
    input logic [1:0]           ref_sel,
    input logic                 rd_valid,
    input logic                 ecc_submit,
    input logic                 ecc_pass,
    input logic                 ecc_fail,
    input logic [PAGE_BITS-1:0] page_q,
    input logic                 busy,
    input logic                 done,
    input logic                 uncorrectable
);
    p_first_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && !$past(ecc_submit)) |-> (ref_sel == 2'b11));

    p_cand_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_req) && $past(ecc_submit)) |-> (ref_sel == $past(ref_sel) - 2'd1));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(ref_sel)));

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && ecc_submit));

    p_submit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_submit && !ecc_pass && !ecc_fail) |=> ecc_submit);

    p_pass_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_submit && ecc_pass) |=> (done && !uncorrectable && !busy));

    p_unc_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> done);

    p_idle_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(page_q));
endmodule

bind nbr_retry_corrector nac_checker #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .ref_sel(ref_sel),
    .rd_valid(rd_valid), .ecc_submit(ecc_submit), .ecc_pass(ecc_pass),
    .ecc_fail(ecc_fail), .page_q(page_q), .busy(busy), .done(done),
    .uncorrectable(uncorrectable)
);

// File: tb/sim_nbr_retry_corrector.sv
// Scoreboard bench: the driver pushes the expected outcome, the monitor
// pops it when done pulses and compares page and verdict.
module sim_nbr_retry_corrector;
    localparam int PB = 64;
    localparam int WB = 16;
    localparam int NW = PB / WB;

    typedef struct packed {
        logic [PB-1:0] page;
        logic          unc;
    } exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start, ld_valid, rd_valid, ecc_pass, ecc_fail;
    logic [WB-1:0] ld_page, ld_nbr_lsb, ld_nbr_msb, rd_data;
    logic          rd_req, ecc_submit, busy, done, uncorrectable;
    logic [1:0]    ref_sel;
    logic [PB-1:0] page_q;

    nbr_retry_corrector #(.PAGE_BITS(PB), .WORD_BITS(WB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_valid(ld_valid),
        .ld_page(ld_page), .ld_nbr_lsb(ld_nbr_lsb), .ld_nbr_msb(ld_nbr_msb),
        .rd_req(rd_req), .ref_sel(ref_sel), .rd_valid(rd_valid),
        .rd_data(rd_data), .ecc_submit(ecc_submit), .ecc_pass(ecc_pass),
        .ecc_fail(ecc_fail), .page_q(page_q), .busy(busy), .done(done),
        .uncorrectable(uncorrectable)
    );

    int tests = 0;
    int fails = 0;
    exp_t sb_q[$];

    logic [WB-1:0] pg [NW];
    logic [WB-1:0] lsb[NW];
    logic [WB-1:0] msb[NW];
    logic [WB-1:0] rr [4][NW];

    task automatic chk(input bit ok, input string req, input logic [PB-1:0] act,
                       input logic [PB-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [PB-1:0] flat_loaded();
        logic [PB-1:0] f;
        for (int w = 0; w < NW; w++) f[w*WB +: WB] = pg[w];
        return f;
    endfunction

    // Model: apply rounds 0..upto; round c uses neighbour value 3-c.
    function automatic logic [PB-1:0] model_page(input int upto);
        logic [WB-1:0] p[NW];
        logic [PB-1:0] f;
        for (int w = 0; w < NW; w++) p[w] = pg[w];
        for (int c = 0; c <= upto; c++) begin
            for (int w = 0; w < NW; w++)
                for (int b = 0; b < WB; b++)
                    if ({msb[w][b], lsb[w][b]} == 2'(3 - c)) p[w][b] = rr[c][w][b];
        end
        for (int w = 0; w < NW; w++) f[w*WB +: WB] = p[w];
        return f;
    endfunction

    task automatic gen(input bit fixed_nbr);
        for (int w = 0; w < NW; w++) begin
            pg[w]  = WB'($urandom);
            lsb[w] = fixed_nbr ? 16'hF0F0 : WB'($urandom);
            msb[w] = fixed_nbr ? 16'hFF00 : WB'($urandom);
            for (int c = 0; c < 4; c++) rr[c][w] = WB'($urandom);
        end
    endtask

    task automatic run_case(input int pass_at, input bit gaps, input bit inject);
        exp_t e;
        e.page = model_page(pass_at > 3 ? 3 : pass_at);
        e.unc  = (pass_at > 3);
        sb_q.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R2: one word per valid beat, gaps do not advance
        for (int w = 0; w < NW; w++) begin
            if (gaps) begin
                ld_valid = 1'b0;
                @(negedge clk);
            end
            ld_valid = 1'b1;
            ld_page = pg[w]; ld_nbr_lsb = lsb[w]; ld_nbr_msb = msb[w];
            @(negedge clk);
        end
        ld_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            while (!rd_req) @(negedge clk);
            if (c == 0) chk(page_q == flat_loaded(), "R2 loaded page", page_q, flat_loaded());
            chk(ref_sel == 2'(3 - c), "R3 candidate order", PB'(ref_sel), PB'(3 - c));
            for (int w = 0; w < NW; w++) begin
                if (gaps && w == 1) begin
                    rd_valid = 1'b0;
                    @(negedge clk);
                    chk(rd_req && ref_sel == 2'(3 - c), "R4 request held",
                        PB'({rd_req, ref_sel}), PB'({1'b1, 2'(3 - c)}));
                end
                rd_valid = 1'b1;
                rd_data  = rr[c][w];
                @(negedge clk);
            end
            rd_valid = 1'b0;
            chk(ecc_submit && !rd_req, "R7 submit after merge",
                PB'({ecc_submit, rd_req}), PB'(2'b10));
            if (inject) begin
                rd_valid = 1'b1;
                rd_data  = ~rr[c][0];
                start    = 1'b1;
                @(negedge clk);
                rd_valid = 1'b0;
                start    = 1'b0;
                chk(ecc_submit, "R7 submit held", PB'(ecc_submit), PB'(1));
            end
            if (c == pass_at) ecc_pass = 1'b1;
            else ecc_fail = 1'b1;
            start = inject;
            @(negedge clk);
            ecc_pass = 1'b0; ecc_fail = 1'b0; start = 1'b0;
            if (c == pass_at || c == 3) begin
                chk(!busy, "R8 idle after verdict", PB'(busy), PB'(0));
                @(negedge clk);
                chk(!busy && !rd_req, "R1 start ignored while busy",
                    PB'({busy, rd_req}), PB'(0));
                return;
            end
        end
    endtask

    // Monitor: pop expected item on each completion pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected done", PB'(done), PB'(0));
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(page_q == e.page, "R5/R6 merged page", page_q, e.page);
                chk(uncorrectable == e.unc, "R8/R9 outcome", PB'(uncorrectable), PB'(e.unc));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R8 watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; ld_valid = 1'b0; rd_valid = 1'b0;
        ecc_pass = 1'b0; ecc_fail = 1'b0;
        ld_page = '0; ld_nbr_lsb = '0; ld_nbr_msb = '0; rd_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_req && !ecc_submit && !done, "R1 reset state",
            PB'({busy, rd_req, ecc_submit, done}), PB'(0));
        // R5: fixed pattern covers all four neighbour values in every word
        gen(1'b1); run_case(0, 1'b0, 1'b0);
        // R6: accumulation over three rounds with stalls
        gen(1'b0); run_case(2, 1'b1, 1'b0);
        // R9: all candidates fail, with stray data and triggers
        gen(1'b0); run_case(4, 1'b0, 1'b1);
        repeat (6) @(negedge clk);
        chk(page_q == model_page(3), "R9 page kept in idle", page_q, model_page(3));
        gen(1'b0); run_case(1, 1'b1, 1'b1);
        gen(1'b1); run_case(3, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R8 all completions seen", PB'(sb_q.size()), PB'(0));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule